// File: doc/BRIEF.md
# Byte-wide SPI shift port with host handshake

This peripheral lets a processor on a 16-bit register bus talk to two SPI slaves, one byte per transaction. The host loads a byte into the data register and raises a start strobe in the control register. The port answers with a loaded flag and holds there until the host drops the strobe. It then clocks eight bits out, most significant bit first, and raises a done flag. For a read, the host sets the direction bit as well. The byte clocked in from the slave replaces the data register contents at the moment done rises.

The two slave-select lines are plain register bits with active-low pins. They stay asserted between bytes for as long as the host leaves them set. Longer frames are built by the host from repeated byte transactions, most significant byte first. The serial clock idles low and runs at the system clock divided by the even parameter `DIV`.

Top module: `spi_byte_port`

## Requirements
- R1: Address 1 is the control register: bit 0 codec select, bit 1 touch select, bit 2 direction (1 = read), bit 3 done (read-only), bit 4 strobe, bit 5 loaded (read-only), all other bits read 0. Address 0 holds the data byte in bits 7:0. Both registers read 0 after reset, and writes to bits 3 and 5 have no effect.
- R2: `cs_codec_n` and `cs_touch_n` are the inverse of control bits 0 and 1 from the cycle after the control write. A control write with both bits clear drives both pins high. Serial clocks reach only the selected slave.
- R3: A strobe seen while the shifter is idle sets loaded one cycle later and clears done in the same cycle.
- R4: While the strobe stays set after loaded, no serial clock edge occurs. Clearing the strobe clears loaded and starts the shift.
- R5: Exactly eight bits are shifted, MSB first. `mosi` changes only on falling `sclk` edges, and `sclk` is low whenever the port is not shifting.
- R6: Each `sclk` half period lasts DIV/2 system clocks, so consecutive rising edges are DIV clocks apart.
- R7: Done sets after the eighth falling edge and stays set until the next accepted strobe. Loaded and done are never set together.
- R8: In a read, `miso` is sampled on rising edges, and the received byte is in the data register when done is set.
- R9: In a write, the bits received are discarded and the data register keeps the transmitted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data of the register addressed in the previous cycle |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the slaves |
| cs_codec_n | output | 1 | Active-low select of the codec slave |
| cs_touch_n | output | 1 | Active-low select of the touch slave |

## Verification
Every one of the 256 byte values is written through the port, alternating between the two selects. This sweep separates bit-order and lost-bit faults from select routing faults, because a wrong slave receives clocks or a wrong bit lands. A second sweep reads all 256 patterns from the slave model while it drives the data register to a different value. A port that keeps the old byte, or that samples on the wrong edge, then shows a mismatch. Some transactions hold the strobe for extra cycles to show that the shift waits. Control writes with status bits set, and with no selects set, show that status cannot be written and that the pins release.

// File: rtl/spi_byte_port_pkg.sv
package spi_byte_port_pkg;
  localparam int CTRL_CS_CODEC = 0;
  localparam int CTRL_CS_TOUCH = 1;
  localparam int CTRL_DIR      = 2;
  localparam int CTRL_DONE     = 3;
  localparam int CTRL_STROBE   = 4;
  localparam int CTRL_LOADED   = 5;
  localparam int CTRL_USED     = 6;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef enum logic [1:0] {
    SH_IDLE   = 2'd0,
    SH_LOADED = 2'd1,
    SH_SHIFT  = 2'd2
  } sh_state_t;
endpackage

// File: rtl/spi_byte_port_clkgen.sv
module spi_byte_port_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == CW'(HALF - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_byte_port_shifter.sv
module spi_byte_port_shifter
  import spi_byte_port_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              dir_rd,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  input  logic              tick,
  output logic              run,
  output logic              loaded,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic              rx_take,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BW = $clog2(BYTE_W);

  sh_state_t         state_q;
  logic [BW-1:0]     bit_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic              dir_q;
  logic              loaded_q;
  logic              done_q;
  logic              sclk_q;
  logic              last_fall;

  assign last_fall = (state_q == SH_SHIFT) && tick && sclk_q &&
                     (bit_q == BW'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SH_IDLE;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      dir_q    <= 1'b0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SH_IDLE: begin
          if (strobe) begin
            state_q  <= SH_LOADED;
            loaded_q <= 1'b1;
            done_q   <= 1'b0;
            tx_q     <= tx_byte;
            dir_q    <= dir_rd;
            bit_q    <= '0;
            sclk_q   <= 1'b0;
          end
        end
        SH_LOADED: begin
          if (!strobe) begin
            state_q  <= SH_SHIFT;
            loaded_q <= 1'b0;
          end
        end
        SH_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_q   <= {rx_q[BYTE_W-2:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (last_fall) begin
                state_q <= SH_IDLE;
                done_q  <= 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign run     = (state_q == SH_SHIFT);
  assign loaded  = loaded_q;
  assign done    = done_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[BYTE_W-1];
  assign rx_take = last_fall && dir_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_byte_port_regs.sv
module spi_byte_port_regs
  import spi_byte_port_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              loaded,
  input  logic              done,
  input  logic              rx_take,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [1:0]        sel,
  output logic              dir_rd,
  output logic              strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              cs_codec_n,
  output logic              cs_touch_n
);
  logic [BUS_W-1:0] ctrl_view;
  logic [BUS_W-1:0] data_view;

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_CS_CODEC] = sel[0];
    ctrl_view[CTRL_CS_TOUCH] = sel[1];
    ctrl_view[CTRL_DIR]      = dir_rd;
    ctrl_view[CTRL_DONE]     = done;
    ctrl_view[CTRL_STROBE]   = strobe;
    ctrl_view[CTRL_LOADED]   = loaded;
    data_view                = '0;
    data_view[BYTE_W-1:0]    = tx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel        <= '0;
      dir_rd     <= 1'b0;
      strobe     <= 1'b0;
      tx_byte    <= '0;
      cs_codec_n <= 1'b1;
      cs_touch_n <= 1'b1;
      bus_rdata  <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_CTRL) begin
        sel        <= {bus_wdata[CTRL_CS_TOUCH], bus_wdata[CTRL_CS_CODEC]};
        dir_rd     <= bus_wdata[CTRL_DIR];
        strobe     <= bus_wdata[CTRL_STROBE];
        cs_codec_n <= ~bus_wdata[CTRL_CS_CODEC];
        cs_touch_n <= ~bus_wdata[CTRL_CS_TOUCH];
      end
      if (rx_take)
        tx_byte <= rx_byte;
      else if (bus_wr && bus_addr == ADDR_DATA)
        tx_byte <= bus_wdata[BYTE_W-1:0];
      bus_rdata <= (bus_addr == ADDR_CTRL) ? ctrl_view : data_view;
    end
  end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
  parameter int DIV    = 8,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_codec_n,
  output logic             cs_touch_n
);
  logic [1:0]        sel;
  logic              dir_rd;
  logic              strobe;
  logic [BYTE_W-1:0] tx_byte;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_take;
  logic              loaded;
  logic              done;
  logic              run;
  logic              tick;

  spi_byte_port_regs #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .loaded     (loaded),
    .done       (done),
    .rx_take    (rx_take),
    .rx_byte    (rx_byte),
    .sel        (sel),
    .dir_rd     (dir_rd),
    .strobe     (strobe),
    .tx_byte    (tx_byte),
    .cs_codec_n (cs_codec_n),
    .cs_touch_n (cs_touch_n)
  );

  spi_byte_port_clkgen #(.DIV(DIV)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  spi_byte_port_shifter #(.BYTE_W(BYTE_W)) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dir_rd  (dir_rd),
    .tx_byte (tx_byte),
    .miso    (miso),
    .tick    (tick),
    .run     (run),
    .loaded  (loaded),
    .done    (done),
    .sclk    (sclk),
    .mosi    (mosi),
    .rx_take (rx_take),
    .rx_byte (rx_byte)
  );
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk #(
  parameter int DIV   = 8,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             sclk,
  input logic             cs_codec_n,
  input logic             cs_touch_n,
  input logic             loaded,
  input logic             done,
  input logic             strobe
);
  localparam int HALF = DIV / 2;

  logic        sclk_d;
  logic [15:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      gap_q  <= 16'd0;
    end else begin
      sclk_d <= sclk;
      if (sclk != sclk_d)
        gap_q <= 16'd1;
      else if (gap_q != 16'hFFFF)
        gap_q <= gap_q + 16'd1;
    end
  end

  p_loaded_no_done_r7: assert property (@(posedge clk) disable iff (rst)
    !(loaded && done));

  p_sclk_low_loaded_r4: assert property (@(posedge clk) disable iff (rst)
    loaded |-> !sclk);

  p_sclk_low_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !sclk);

  p_loaded_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(loaded) |-> $past(strobe));

  p_done_clear_accept_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> ($past(strobe) && loaded));

  p_cs_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr) |=> (cs_codec_n == !$past(bus_wdata[0]) &&
                              cs_touch_n == !$past(bus_wdata[1])));

  p_half_period_r6: assert property (@(posedge clk) disable iff (rst)
    (sclk_d && !sclk) |-> (gap_q == 16'(HALF)));
endmodule

bind spi_byte_port spi_byte_port_chk #(.DIV(DIV), .BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .sclk       (sclk),
  .cs_codec_n (cs_codec_n),
  .cs_touch_n (cs_touch_n),
  .loaded     (loaded),
  .done       (done),
  .strobe     (strobe)
);

// File: tb/tb_spi_byte_port.sv
`timescale 1ns/1ps
module tb_spi_byte_port;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sclk, mosi, miso, cs_codec_n, cs_touch_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  spi_byte_port #(.DIV(DIV)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_codec_n(cs_codec_n), .cs_touch_n(cs_touch_n)
  );

  // slave model
  logic [7:0] s_rx_c = '0, s_rx_t = '0, s_tx = '0, s_pat = '0;
  logic       s_load = 1'b0;
  int rise_c = 0, rise_t = 0, rise_all = 0, byte_start = 0;
  realtime last_rise = 0.0;
  bit period_bad = 1'b0;

  assign miso = s_tx[7];

  always @(posedge sclk) begin
    if (!cs_codec_n) begin s_rx_c = {s_rx_c[6:0], mosi}; rise_c++; end
    if (!cs_touch_n) begin s_rx_t = {s_rx_t[6:0], mosi}; rise_t++; end
    if (rise_all > byte_start && ($realtime - last_rise) != DIV * 5.0)
      period_bad = 1'b1;
    last_rise = $realtime;
    rise_all++;
  end

  always @(negedge sclk or posedge s_load) begin
    if (s_load) s_tx <= s_pat;
    else        s_tx <= {s_tx[6:0], 1'b0};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic xfer(input logic [1:0] sel, input bit read, input logic [7:0] b,
                      input logic [7:0] pat, input int hold);
    logic [15:0] v;
    int c0, t0, n;
    bit got;
    c0 = rise_c; t0 = rise_t; byte_start = rise_all; period_bad = 1'b0;
    s_pat = pat;
    s_load = 1'b1; #1; s_load = 1'b0;
    wr(1'b0, {8'h00, b});
    wr(1'b1, 16'(sel) | (16'(read) << 2) | 16'h0010);
    got = 1'b0; n = 0;
    while (!got && n < 20) begin rd(1'b1, v); got = v[5]; n++; end
    chk(got, "R3 loaded set", int'(v), 32'h20);
    chk(v[3] == 1'b0, "R3 done cleared on accept", int'(v[3]), 0);
    repeat (hold) @(negedge clk);
    chk(rise_all == byte_start, "R4 no sclk while strobe held", rise_all - byte_start, 0);
    wr(1'b1, 16'(sel) | (16'(read) << 2));
    got = 1'b0; n = 0;
    while (!got && n < 200) begin rd(1'b1, v); got = v[3]; n++; end
    chk(got, "R7 done set", int'(v), 32'h08);
    chk(v[5] == 1'b0, "R7 loaded clear with done", int'(v[5]), 0);
    chk(sclk == 1'b0, "R5 sclk idle low", int'(sclk), 0);
    chk(rise_c - c0 == (sel[0] ? 8 : 0), "R2 codec clock count", rise_c - c0, sel[0] ? 8 : 0);
    chk(rise_t - t0 == (sel[1] ? 8 : 0), "R2 touch clock count", rise_t - t0, sel[1] ? 8 : 0);
    chk(!period_bad, "R6 sclk period", int'(period_bad), 0);
    rd(1'b0, v);
    if (read) begin
      chk(v == {8'h00, pat}, "R8 read byte in data register", int'(v), int'(pat));
    end else begin
      chk((sel[0] ? s_rx_c : s_rx_t) == b, "R5 slave received byte",
          int'(sel[0] ? s_rx_c : s_rx_t), int'(b));
      chk(v == {8'h00, b}, "R9 write keeps data register", int'(v), int'(b));
    end
  endtask

  initial begin
    #950000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(1'b1, v);
    chk(v == 16'h0, "R1 control reset", int'(v), 0);
    rd(1'b0, v);
    chk(v == 16'h0, "R1 data reset", int'(v), 0);
    chk(cs_codec_n && cs_touch_n, "R2 selects idle high", int'({cs_touch_n, cs_codec_n}), 3);
    chk(sclk == 1'b0, "R5 sclk low after reset", int'(sclk), 0);

    wr(1'b1, 16'h0028);
    rd(1'b1, v);
    chk(v == 16'h0, "R1 status bits not writable", int'(v), 0);
    wr(1'b1, 16'h0003);
    chk(!cs_codec_n && !cs_touch_n, "R2 both selects low", int'({cs_touch_n, cs_codec_n}), 0);
    wr(1'b1, 16'h0002);
    chk(cs_codec_n && !cs_touch_n, "R2 touch only", int'({cs_touch_n, cs_codec_n}), 1);
    wr(1'b1, 16'h0000);
    chk(cs_codec_n && cs_touch_n, "R2 none selected", int'({cs_touch_n, cs_codec_n}), 3);

    for (int i = 0; i < 256; i++)
      xfer((i % 2 == 0) ? 2'b01 : 2'b10, 1'b0, 8'(i), 8'(255 - i), (i % 16 == 0) ? 12 : 0);

    for (int i = 0; i < 256; i++)
      xfer((i % 2 == 0) ? 2'b10 : 2'b01, 1'b1, 8'(i ^ 8'h5A), 8'(i), (i % 32 == 1) ? 9 : 0);

    wr(1'b1, 16'h0008);
    rd(1'b1, v);
    chk(v == 16'h0008, "R1 done held, write ignored", int'(v), 8);
    chk(cs_codec_n && cs_touch_n, "R2 release after transfers", int'({cs_touch_n, cs_codec_n}), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule